// File: doc/BRIEF.md
# Host Bridge Command Register with Chain-Side Access Control

This block holds the command register of a host bridge that can share its chain with a second host at the far end. Configuration accesses reach it from two places: the internal side (the processor complex behind the bridge) and the chain side (a host at the other end of the chain). Each access arrives as a single-cycle request with a side indicator. One clock later the block returns a response that carries read data and a no-target flag.

On chain-side accesses the register can be hidden. While hidden, the bridge answers chain-side requests as an end-of-chain device would: the response carries the no-target flag and all-ones data, and writes have no effect. The read value reports which side the access came from. A slave-mode bit makes the interface source its packets with a programmed base unit identifier and without the bridge flag.

The parameter `DHC_EN` chooses between two variants of the register. With `DHC_EN=1` the block supports a chain with a host at each end. With `DHC_EN=0` it is a host for a chain with a single host, and the double-ended, side and slave bits are tied off.

Top module: `hbcmd_top`

## Requirements
- R1: After cold reset with `DHC_EN=1`, an internal read returns 0x0000, `src_unit_id` is 0 and `src_bridge_flag` is 1.
- R2: Bit 7 of the read data is 1 for a chain-side read and 0 for an internal read.
- R3: Bit 1 (double-ended) is read-write. Its value changes neither `src_unit_id` nor `src_bridge_flag`.
- R4: While bit 8 (hide) is 1, a chain-side access gets a response with `rsp_no_target`=1 and `rsp_rdata` all ones. A chain-side write in that state changes no register bit.
- R5: Internal accesses are never hidden. A chain-side write is applied when hide is 0.
- R6: Bits 6:2 form a read-write five-bit base identifier field.
- R7: When bit 10 (slave) is 1, `src_unit_id` equals bits 6:2 and `src_bridge_flag` is 0. When bit 10 is 0, `src_unit_id` is 0 and `src_bridge_flag` is 1. A register write shows on these outputs from the cycle after the write.
- R8: Warm reset clears only bit 8. Cold reset clears every field. When both resets are asserted together, cold reset wins.
- R9: Bit 7 and the undefined bits (0, 9, 11 and up) read as 0 and ignore writes.
- R10: With `DHC_EN=0`, bits 1, 7 and 10 read as 0 and bit 8 reads as 1, whatever is written. Every chain-side access is therefore answered as no-target.
- R11: `rsp_valid` is 1 exactly one cycle after an accepted request and 0 otherwise. A serviced write returns `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| acc_valid | input | 1 | Configuration access request |
| acc_chain | input | 1 | 1: access from chain side, 0: from internal side |
| acc_write | input | 1 | 1: write, 0: read |
| acc_wdata | input | REG_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_no_target | output | 1 | Access was hidden (end-of-chain answer) |
| rsp_rdata | output | REG_W | Read data of the response |
| src_unit_id | output | ID_W | Base unit identifier for sourced packets |
| src_bridge_flag | output | 1 | Bridge flag for sourced responses |

## Verification
The bench aims at the cases where the side of an access changes the result. A design that serviced a hidden chain-side write would lose the base field that the bench reads back afterwards. A design that hid internal accesses as well would lock software out of the register. The bench also asserts warm and cold reset together; a design that gave warm reset priority would keep the slave bit and the base field. A second instance built without double-hosted support must answer every chain-side access as no-target and show hide as 1. A variant that left the tied bits writable would return the wrong read value there.

// File: rtl/hbcmd_pkg.sv
package hbcmd_pkg;
   localparam int ID_W      = 5;
   localparam int ID_LSB    = 2;
   localparam int BIT_DBL   = 1;
   localparam int BIT_SIDE  = 7;
   localparam int BIT_HIDE  = 8;
   localparam int BIT_SLAVE = 10;
   localparam int MIN_REG_W = BIT_SLAVE + 1;

   typedef struct packed {
      logic            dbl;
      logic            hide;
      logic            slave;
      logic [ID_W-1:0] base;
   } cmd_state_t;
endpackage

// File: rtl/hbcmd_filter.sv
module hbcmd_filter (
   input  logic acc_valid,
   input  logic acc_chain,
   input  logic hide,
   output logic wr_ok,
   output logic hidden
);
   always_comb begin
      hidden = acc_valid && acc_chain && hide;
      wr_ok  = acc_valid && !hidden;
   end
endmodule

// File: rtl/hbcmd_reg.sv
module hbcmd_reg
   import hbcmd_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter bit DHC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             cold_rst,
   input  logic             warm_rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output cmd_state_t       state
);
   logic [ID_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (cold_rst)
         base_q <= '0;
      else if (wr_en && !warm_rst)
         base_q <= wdata[ID_LSB +: ID_W];
   end

   generate
      if (DHC_EN) begin : g_dhc
         logic dbl_q, hide_q, slave_q;
         always_ff @(posedge clk) begin
            if (cold_rst) begin
               dbl_q   <= 1'b0;
               hide_q  <= 1'b0;
               slave_q <= 1'b0;
            end else if (warm_rst) begin
               hide_q  <= 1'b0;
            end else if (wr_en) begin
               dbl_q   <= wdata[BIT_DBL];
               hide_q  <= wdata[BIT_HIDE];
               slave_q <= wdata[BIT_SLAVE];
            end
         end
         always_comb begin
            state.dbl   = dbl_q;
            state.hide  = hide_q;
            state.slave = slave_q;
            state.base  = base_q;
         end

         // R8: cold reset clears every field, also when warm reset is set
         p_cold_clears_r8: assert property (@(posedge clk)
            cold_rst |=> (!dbl_q && !hide_q && !slave_q && base_q == '0));
         // R8: warm reset alone keeps the cold-only fields
         p_warm_keeps_r8: assert property (@(posedge clk) disable iff (cold_rst)
            warm_rst |=> (!hide_q && $stable(dbl_q) && $stable(slave_q)));
      end else begin : g_single
         logic unused_wbits;
         assign unused_wbits = ^{wdata[BIT_DBL], wdata[BIT_HIDE], wdata[BIT_SLAVE]};
         always_comb begin
            state.dbl   = 1'b0;
            state.hide  = 1'b1;
            state.slave = 1'b0;
            state.base  = base_q;
         end
      end
   endgenerate

   // R8: warm reset never touches the base field
   p_warm_base_r8: assert property (@(posedge clk) disable iff (cold_rst)
      warm_rst |=> $stable(base_q));
endmodule

// File: rtl/hbcmd_readback.sv
module hbcmd_readback
   import hbcmd_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter bit DHC_EN = 1'b1
) (
   input  cmd_state_t       state,
   input  logic             acc_chain,
   output logic [REG_W-1:0] rd_value
);
   always_comb begin
      rd_value                    = '0;
      rd_value[BIT_DBL]           = state.dbl;
      rd_value[ID_LSB +: ID_W]    = state.base;
      rd_value[BIT_SIDE]          = DHC_EN ? acc_chain : 1'b0;
      rd_value[BIT_HIDE]          = state.hide;
      rd_value[BIT_SLAVE]         = state.slave;
   end
endmodule

// File: rtl/hbcmd_src_id.sv
module hbcmd_src_id
   import hbcmd_pkg::*;
(
   input  cmd_state_t      state,
   output logic [ID_W-1:0] unit_id,
   output logic            bridge_flag
);
   always_comb begin
      if (state.slave) begin
         unit_id     = state.base;
         bridge_flag = 1'b0;
      end else begin
         unit_id     = '0;
         bridge_flag = 1'b1;
      end
   end
endmodule

// File: rtl/hbcmd_top.sv
module hbcmd_top
   import hbcmd_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter bit DHC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             cold_rst,
   input  logic             warm_rst,
   input  logic             acc_valid,
   input  logic             acc_chain,
   input  logic             acc_write,
   input  logic [REG_W-1:0] acc_wdata,
   output logic             rsp_valid,
   output logic             rsp_no_target,
   output logic [REG_W-1:0] rsp_rdata,
   output logic [ID_W-1:0]  src_unit_id,
   output logic             src_bridge_flag
);
   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("hbcmd_top: REG_W too small for the command fields");
      end
   endgenerate

   cmd_state_t       state;
   logic             wr_ok, hidden;
   logic [REG_W-1:0] rd_value;

   hbcmd_filter u_filter (
      .acc_valid (acc_valid),
      .acc_chain (acc_chain),
      .hide      (state.hide),
      .wr_ok     (wr_ok),
      .hidden    (hidden)
   );

   hbcmd_reg #(.REG_W(REG_W), .DHC_EN(DHC_EN)) u_reg (
      .clk      (clk),
      .cold_rst (cold_rst),
      .warm_rst (warm_rst),
      .wr_en    (wr_ok && acc_write),
      .wdata    (acc_wdata),
      .state    (state)
   );

   hbcmd_readback #(.REG_W(REG_W), .DHC_EN(DHC_EN)) u_rb (
      .state     (state),
      .acc_chain (acc_chain),
      .rd_value  (rd_value)
   );

   hbcmd_src_id u_id (
      .state       (state),
      .unit_id     (src_unit_id),
      .bridge_flag (src_bridge_flag)
   );

   always_ff @(posedge clk) begin
      if (cold_rst || warm_rst) begin
         rsp_valid     <= 1'b0;
         rsp_no_target <= 1'b0;
         rsp_rdata     <= '0;
      end else begin
         rsp_valid     <= acc_valid;
         rsp_no_target <= hidden;
         if (hidden)
            rsp_rdata <= '1;
         else if (acc_valid && !acc_write)
            rsp_rdata <= rd_value;
         else
            rsp_rdata <= '0;
      end
   end

   // R4: a hidden chain-side access is answered as no-target with all ones
   p_hidden_answer_r4: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      (acc_valid && acc_chain && state.hide) |=> (rsp_valid && rsp_no_target && &rsp_rdata));
   // R4: a hidden write leaves the register unchanged
   p_hidden_write_r4: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      (acc_valid && acc_write && acc_chain && state.hide) |=> $stable(state));
   // R5: internal accesses are always serviced
   p_internal_open_r5: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      (acc_valid && !acc_chain) |=> (rsp_valid && !rsp_no_target));
   // R7: an asserted bridge flag goes with unit identifier 0
   p_bridge_id_r7: assert property (@(posedge clk) disable iff (cold_rst)
      src_bridge_flag |-> (src_unit_id == '0));
   // R11: a response follows only a request
   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      !acc_valid |=> !rsp_valid);

   generate
      if (!DHC_EN) begin : g_single_chk
         // R10: without double-hosted support the chain side never gets in
         p_chain_blocked_r10: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
            (acc_valid && acc_chain) |=> rsp_no_target);
      end
   endgenerate
endmodule

// File: tb/hbcmd_top_tb_top.sv
module hbcmd_top_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         cold_rst, warm_rst;
   logic         acc_valid, acc_chain, acc_write;
   logic [W-1:0] acc_wdata;

   logic         rv, rnt, rv2, rnt2;
   logic [W-1:0] rd, rd2;
   logic [4:0]   uid, uid2;
   logic         bf, bf2;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   hbcmd_top #(.REG_W(W), .DHC_EN(1'b1)) dut_i (
      .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
      .acc_valid(acc_valid), .acc_chain(acc_chain), .acc_write(acc_write),
      .acc_wdata(acc_wdata), .rsp_valid(rv), .rsp_no_target(rnt),
      .rsp_rdata(rd), .src_unit_id(uid), .src_bridge_flag(bf));

   hbcmd_top #(.REG_W(W), .DHC_EN(1'b0)) nd_i (
      .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
      .acc_valid(acc_valid), .acc_chain(acc_chain), .acc_write(acc_write),
      .acc_wdata(acc_wdata), .rsp_valid(rv2), .rsp_no_target(rnt2),
      .rsp_rdata(rd2), .src_unit_id(uid2), .src_bridge_flag(bf2));

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // drive one access after a falling edge, sample the response one falling edge later
   task automatic access(input logic chain, input logic wr, input logic [W-1:0] data);
      acc_valid = 1'b1; acc_chain = chain; acc_write = wr; acc_wdata = data;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
   endtask

   task automatic do_resets(input logic c, input logic w);
      cold_rst = c; warm_rst = w;
      @(negedge clk);
      cold_rst = 1'b0; warm_rst = 1'b0;
   endtask

   task automatic t_reset_state();
      do_resets(1'b1, 1'b0);
      chk("R1", "unit id", uid, 0);
      chk("R1", "bridge flag", bf, 1);
      access(1'b0, 1'b0, '0);
      chk("R1", "internal read", rd, 16'h0000);
      chk("R11", "rsp_valid after read", rv, 1);
      chk("R10", "single-host internal read", rd2, 16'h0100);
      @(negedge clk);
      chk("R11", "rsp_valid idle", rv, 0);
      access(1'b1, 1'b0, '0);
      chk("R2", "chain read side bit", rd, 16'h0080);
      chk("R10", "single-host chain no-target", rnt2, 1);
      chk("R10", "single-host chain data", rd2, 16'hFFFF);
   endtask

   task automatic t_write_all_ones();
      access(1'b0, 1'b1, 16'hFFFF);
      chk("R11", "write response data", rd, 0);
      chk("R7", "slave unit id", uid, 5'h1F);
      chk("R7", "slave bridge flag", bf, 0);
      chk("R10", "single-host bridge flag", bf2, 1);
      access(1'b0, 1'b0, '0);
      chk("R9", "writable bits only", rd, 16'h057E);
      chk("R10", "single-host tied bits", rd2, 16'h017C);
   endtask

   task automatic t_hidden_chain();
      access(1'b1, 1'b0, '0);
      chk("R4", "hidden read no-target", rnt, 1);
      chk("R4", "hidden read data", rd, 16'hFFFF);
      access(1'b1, 1'b1, 16'h0000);
      chk("R4", "hidden write no-target", rnt, 1);
      access(1'b0, 1'b0, '0);
      chk("R4", "hidden write discarded", rd, 16'h057E);
      chk("R5", "internal not hidden", rnt, 0);
   endtask

   task automatic t_double_ended();
      access(1'b0, 1'b1, 16'h0026);
      chk("R3", "unit id with bit1", uid, 0);
      chk("R3", "bridge flag with bit1", bf, 1);
      access(1'b1, 1'b0, '0);
      chk("R2", "chain read reports side", rd, 16'h00A6);
      chk("R6", "chain read no-target", rnt, 0);
   endtask

   task automatic t_chain_write();
      access(1'b1, 1'b1, 16'h0434);
      chk("R5", "chain write serviced", rnt, 0);
      chk("R7", "unit id from base", uid, 5'd13);
      chk("R7", "bridge cleared", bf, 0);
      access(1'b0, 1'b0, '0);
      chk("R6", "base field readback", rd, 16'h0434);
      chk("R10", "single-host chain write dropped", rd2, 16'h0124);
   endtask

   task automatic t_resets();
      access(1'b0, 1'b1, 16'h0534);
      do_resets(1'b0, 1'b1);
      access(1'b0, 1'b0, '0);
      chk("R8", "warm reset clears hide only", rd, 16'h0434);
      chk("R8", "unit id kept by warm", uid, 5'd13);
      do_resets(1'b1, 1'b1);
      access(1'b0, 1'b0, '0);
      chk("R8", "cold wins over warm", rd, 16'h0000);
      chk("R8", "bridge after cold", bf, 1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cold_rst = 1'b1; warm_rst = 1'b0;
      acc_valid = 1'b0; acc_chain = 1'b0; acc_write = 1'b0; acc_wdata = '0;
      @(negedge clk);
      t_reset_state();
      t_write_all_ones();
      t_hidden_chain();
      t_double_ended();
      t_chain_write();
      t_resets();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule